// File: doc/BRIEF.md
# Programmable Input Level Detector

This block watches a stream of signed samples and reports how strong that stream is as one 32-bit figure. Each sample whose valid strobe is high is first turned into a magnitude. Software then picks one of three ways to reduce the magnitudes:

- a saturating sum over a fixed number of samples;
- a first-order leaky average with a programmable fractional coefficient;
- a running maximum.

A start pulse arms the detector and captures the configuration. From then on, measurement windows follow one another back to back. At the end of each window the result register takes the final value and a one-cycle done pulse marks it. The leaky and peak reductions can also run with no window at all, in which case the result tracks every accepted sample.

The result and done flag are read through the surrounding register interface. Input bus selection and format conversion happen upstream.

Top module: `level_monitor`

## Requirements
- R1: After reset, result is 0 and done is low. No sample is accepted until the first start pulse, so no done pulse occurs before one.
- R2: The mode encoding is as follows. 2'b00 sums magnitudes, 2'b01 is the leaky average, 2'b10 is the peak hold, and 2'b11 leaves the accumulator unchanged, so a window completes with result 0.
- R3: The magnitude of a sample is its absolute value. The most negative input (24'h800000 at default width) maps to the largest positive value, 23'h7FFFFF.
- R4: A span setting N gives a window of exactly N+2 accepted samples, so span 0 gives 2 samples and span 16'hFFFF gives 65537. Cycles with the valid strobe low are not counted. Mode, span, coefficient and free_run are captured on the start pulse.
- R5: The edge that accepts the last sample of a window loads result with the value that includes that sample and raises done for exactly one cycle. The same edge clears the accumulator, so the next window starts from zero.
- R6: In sum mode the accumulator saturates at 32'hFFFFFFFF instead of wrapping.
- R7: In leaky mode each accepted sample updates y to y + floor(coef*(m - y)/65536), where coef is unsigned and m is the magnitude. y starts at 0 on start.
- R8: In peak mode the accumulator keeps the largest magnitude accepted in the window.
- R9: With free_run high in leaky or peak mode, no window ends and done never rises. After each accepted sample, result holds the updated accumulator value. In sum or hold mode, free_run has no effect.
- R10: A start pulse during a window discards the partial window and clears the accumulator and sample count. A sample presented in the start cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms or restarts a measurement and captures the configuration |
| free_run | input | 1 | Continuous operation for leaky and peak modes |
| mode | input | 2 | Reduction selection (see R2) |
| span | input | 16 | Window setting N; window is N+2 samples |
| coef | input | 16 | Leaky coefficient, unsigned fraction of 65536 |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed two's-complement sample |
| result | output | 32 | Latest measurement |
| done | output | 1 | One-cycle pulse when a window completes |

## Verification
The hardest states to reach are the edges of the counting range and of the arithmetic. These are the saturation of the 32-bit sum and the longest window of 65537 samples. Both need hundreds or tens of thousands of accepted samples before anything shows at the ports. The stimulus streams full-scale samples over a window long enough to cross 2^32, and sets a second window just short of it to check the exact sum. It then feeds a full-length window of unit samples and confirms that no done pulse occurs before the last one. Floor rounding of negative leaky steps is covered by a table vector whose final update has a fractional negative delta.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

  typedef enum logic [1:0] {
    LM_SUM  = 2'b00,
    LM_LEAK = 2'b01,
    LM_PEAK = 2'b10,
    LM_HOLD = 2'b11
  } lvl_mode_e;

endpackage

// File: rtl/lvl_magnitude.sv
module lvl_magnitude #(
  parameter int SAMPLE_W = 24,
  localparam int MAG_W   = SAMPLE_W - 1
) (
  input  logic signed [SAMPLE_W-1:0] smp_i,
  output logic        [MAG_W-1:0]    mag_o,
  output logic                       clip_o
);

  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  // absolute value, most negative code clipped to the positive limit
  function automatic logic [MAG_W-1:0] abs_sat(input logic [SAMPLE_W-1:0] x);
    logic [SAMPLE_W-1:0] neg;
    neg = ~x + SAMPLE_W'(1);
    if (x == MOST_NEG)       return {MAG_W{1'b1}};
    else if (x[SAMPLE_W-1])  return neg[MAG_W-1:0];
    else                     return x[MAG_W-1:0];
  endfunction

  assign mag_o  = abs_sat(smp_i);
  assign clip_o = (smp_i == MOST_NEG);

endmodule

// File: rtl/lvl_interval_ctrl.sv
module lvl_interval_ctrl #(
  parameter int SPAN_W = 16,
  localparam int CNT_W = SPAN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              take_i,
  input  logic [SPAN_W-1:0] span_i,
  output logic              last_o
);

  logic [SPAN_W-1:0] span_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;
  logic              at_limit;

  // window of N+2 samples: indices 0 .. N+1
  assign limit    = {1'b0, span_q} + CNT_W'(1);
  assign at_limit = (cnt_q == limit);
  assign last_o   = take_i && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      span_q <= span_i;
      cnt_q  <= '0;
    end else if (take_i) begin
      cnt_q  <= at_limit ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R4: sample index never runs past the end of the window
  a_r4_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R10: a start pulse always rewinds the window
  a_r10_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> cnt_q == '0);

endmodule

// File: rtl/lvl_accum.sv
module lvl_accum
  import lvl_pkg::*;
#(
  parameter int MAG_W  = 23,
  parameter int RES_W  = 32,
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic              last_i,
  input  lvl_mode_e         mode_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [MAG_W-1:0]  mag_i,
  output logic [RES_W-1:0]  acc_o,
  output logic [RES_W-1:0]  acc_next_o
);

  localparam int DW = RES_W + 1;
  localparam int PW = COEF_W + 1 + DW;

  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] mag_ext;

  assign mag_ext = RES_W'(mag_i);

  function automatic logic [RES_W-1:0] sum_sat(input logic [RES_W-1:0] a,
                                               input logic [RES_W-1:0] m);
    logic [RES_W:0] s;
    s = {1'b0, a} + {1'b0, m};
    return s[RES_W] ? {RES_W{1'b1}} : s[RES_W-1:0];
  endfunction

  // y + floor(A*(m-y)) with A = coef / 2^COEF_W, one multiplier
  function automatic logic [RES_W-1:0] leak_step(input logic [RES_W-1:0] y,
                                                 input logic [RES_W-1:0] m,
                                                 input logic [COEF_W-1:0] a);
    logic signed [DW-1:0] diff;
    logic signed [PW-1:0] diff_x;
    logic signed [PW-1:0] a_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] delta;
    diff   = $signed({1'b0, m}) - $signed({1'b0, y});
    diff_x = PW'(diff);
    a_x    = PW'($signed({1'b0, a}));
    prod   = a_x * diff_x;
    delta  = prod >>> COEF_W;
    return y + delta[RES_W-1:0];
  endfunction

  function automatic logic [RES_W-1:0] peak_pick(input logic [RES_W-1:0] y,
                                                 input logic [RES_W-1:0] m);
    return (m > y) ? m : y;
  endfunction

  always_comb begin
    unique case (mode_i)
      LM_SUM:  acc_next_o = sum_sat(acc_q, mag_ext);
      LM_LEAK: acc_next_o = leak_step(acc_q, mag_ext, coef_i);
      LM_PEAK: acc_next_o = peak_pick(acc_q, mag_ext);
      default: acc_next_o = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (take_i)  acc_q <= last_i ? '0 : acc_next_o;
  end

  assign acc_o = acc_q;

  // R6: the sum never decreases inside a window (saturates, no wrap)
  a_r6_sum_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !last_i && !clear_i && mode_i == LM_SUM |=> acc_q >= $past(acc_q));

  // R8: the peak never decreases inside a window
  a_r8_peak_holds: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !last_i && !clear_i && mode_i == LM_PEAK |=> acc_q >= $past(acc_q));

  // R2: hold mode leaves the accumulator untouched
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !last_i && !clear_i && mode_i == LM_HOLD |=> $stable(acc_q));

  // R10: clear always empties the accumulator
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> acc_q == '0);

endmodule

// File: rtl/level_monitor.sv
module level_monitor
  import lvl_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SPAN_W   = 16,
  parameter int COEF_W   = 16,
  parameter int RES_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                free_run,
  input  logic [1:0]          mode,
  input  logic [SPAN_W-1:0]   span,
  input  logic [COEF_W-1:0]   coef,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [RES_W-1:0]    result,
  output logic                done
);

  localparam int MAG_W = SAMPLE_W - 1;

  lvl_mode_e         mode_q;
  logic [COEF_W-1:0] coef_q;
  logic              cont_q;
  logic              armed_q;
  logic [RES_W-1:0]  result_q;
  logic              done_q;

  // named internal events
  logic              take;
  logic              last_raw;
  logic              win_end;
  logic              publish;
  logic              clip;
  logic [MAG_W-1:0]  mag;
  logic [RES_W-1:0]  acc;
  logic [RES_W-1:0]  acc_next;
  logic              cont_req;

  assign take     = smp_valid && armed_q && !start;
  assign win_end  = last_raw && !cont_q;
  assign publish  = take && (win_end || cont_q);
  assign cont_req = free_run && (lvl_mode_e'(mode) == LM_LEAK || lvl_mode_e'(mode) == LM_PEAK);

  lvl_magnitude #(.SAMPLE_W(SAMPLE_W)) u_mag (
    .smp_i  ($signed(smp_data)),
    .mag_o  (mag),
    .clip_o (clip)
  );

  lvl_interval_ctrl #(.SPAN_W(SPAN_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .take_i  (take),
    .span_i  (span),
    .last_o  (last_raw)
  );

  lvl_accum #(.MAG_W(MAG_W), .RES_W(RES_W), .COEF_W(COEF_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start),
    .take_i     (take),
    .last_i     (win_end),
    .mode_i     (mode_q),
    .coef_i     (coef_q),
    .mag_i      (mag),
    .acc_o      (acc),
    .acc_next_o (acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= LM_SUM;
      coef_q  <= '0;
      cont_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (start) begin
      mode_q  <= lvl_mode_e'(mode);
      coef_q  <= coef;
      cont_q  <= cont_req;
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= take && win_end;
      if (publish) result_q <= acc_next;
    end
  end

  assign result = result_q;
  assign done   = done_q;

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: accumulator is empty right after a window closes
  a_r5_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> acc == '0);

  // R9: continuous operation never signals a window end
  a_r9_no_done_cont: assert property (@(posedge clk) disable iff (!rst_n)
    cont_q |-> !done_q);

  // R1: nothing is accepted before the block is armed
  a_r1_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !take);

  // R3: a clipped sample yields the largest magnitude
  a_r3_clip_max: assert property (@(posedge clk) disable iff (!rst_n)
    clip |-> mag == {MAG_W{1'b1}});

endmodule

// File: tb/test_level_monitor.sv
module test_level_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        free_run = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] span = 16'd0;
  logic [15:0] coef = 16'd0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = 24'd0;
  logic [31:0] result;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  level_monitor i_level_monitor (
    .clk(clk), .rst_n(rst_n), .start(start), .free_run(free_run),
    .mode(mode), .span(span), .coef(coef), .smp_valid(smp_valid),
    .smp_data(smp_data), .result(result), .done(done)
  );

  always @(negedge clk) if (done) done_cnt++;

  typedef struct packed {
    logic [1:0]  md;
    logic [15:0] cf;
    logic [23:0] s0, s1, s2, s3;
    logic [31:0] exp;
  } vec_t;

  // span 2 => four samples per window
  localparam vec_t VECS [8] = '{
    '{2'b00, 16'h0000, 24'h00000A, 24'hFFFFEC, 24'h00001E, 24'hFFFFD8, 32'd100},     // R2 R3 sum
    '{2'b00, 16'h0000, 24'h800000, 24'h000000, 24'h000000, 24'h000000, 32'h7FFFFF},  // R3 clip
    '{2'b10, 16'h0000, 24'h000005, 24'hFFFED4, 24'h0000C8, 24'hFFFF9C, 32'd300},     // R8
    '{2'b10, 16'h0000, 24'h800000, 24'h000001, 24'h000002, 24'h000003, 32'h7FFFFF},  // R8 R3
    '{2'b01, 16'h8000, 24'h000064, 24'h000064, 24'hFFFF9C, 24'h000000, 32'd43},      // R7 floor
    '{2'b01, 16'h0000, 24'h0003E8, 24'h0007D0, 24'h0003E8, 24'h0007D0, 32'd0},       // R7 A=0
    '{2'b01, 16'hFFFF, 24'h010000, 24'h010000, 24'h000000, 24'h010000, 32'd65535},   // R7 A~1
    '{2'b11, 16'h0000, 24'h000007, 24'h000008, 24'h000009, 24'h00000A, 32'd0}        // R2 hold
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // called at a negedge; returns at the next negedge with outputs settled
  task automatic feed(input logic [23:0] v);
    smp_valid = 1'b1;
    smp_data  = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [15:0] n,
                       input logic [15:0] a, input logic fr);
    mode = m; span = n; coef = a; free_run = fr;
    pulse_start();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 32'd0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // samples before any start are ignored
    feed(24'd50); feed(24'd60); feed(24'd70);
    check("R1 no done before start", done_cnt, 0);
    check("R1 result idle", result, 32'd0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      setup(VECS[i].md, 16'd2, VECS[i].cf, 1'b0);
      base = done_cnt;
      feed(VECS[i].s0); feed(VECS[i].s1); feed(VECS[i].s2);
      check("R4 no early done", done_cnt - base, 0);
      feed(VECS[i].s3);
      check("R5 done on last sample", {31'd0, done}, 32'd1);
      check("R2 R7 R8 table result", result, VECS[i].exp);
    end

    // R4 window of two with valid gaps
    setup(2'b00, 16'd0, 16'd0, 1'b0);
    base = done_cnt;
    feed(24'd5);
    check("R4 gap first", {31'd0, done}, 32'd0);
    repeat (3) @(negedge clk);
    check("R4 gap not counted", done_cnt - base, 0);
    feed(24'd7);
    check("R4 two-sample window", result, 32'd12);
    // R5 back-to-back windows start from zero
    feed(24'd1);
    check("R5 done single cycle", {31'd0, done}, 32'd0);
    feed(24'd2);
    check("R5 next window fresh", result, 32'd3);

    // R10 restart mid-window
    setup(2'b00, 16'd3, 16'd0, 1'b0);
    base = done_cnt;
    feed(24'd100); feed(24'd100);
    pulse_start();
    for (int k = 0; k < 4; k++) feed(24'd1);
    check("R10 restart count", done_cnt - base, 0);
    feed(24'd1);
    check("R10 restart result", result, 32'd5);

    // R6 just below and above saturation
    setup(2'b00, 16'd509, 16'd0, 1'b0);
    for (int k = 0; k < 511; k++) feed(24'h7FFFFF);
    check("R6 exact sum", result, 32'hFF7FFE01);
    setup(2'b00, 16'd600, 16'd0, 1'b0);
    for (int k = 0; k < 602; k++) feed(24'h7FFFFF);
    check("R6 saturated sum", result, 32'hFFFFFFFF);

    // R4 longest window
    setup(2'b00, 16'hFFFF, 16'd0, 1'b0);
    base = done_cnt;
    for (int k = 0; k < 65536; k++) feed(24'd1);
    check("R4 no done before 65537", done_cnt - base, 0);
    feed(24'd1);
    check("R4 longest window", result, 32'd65537);

    // R9 continuous peak
    setup(2'b10, 16'd0, 16'd0, 1'b1);
    base = done_cnt;
    feed(24'd3);
    check("R9 peak tracks", result, 32'd3);
    feed(24'hFFFFF7);
    check("R9 peak tracks neg", result, 32'd9);
    feed(24'd4);
    check("R9 peak holds", result, 32'd9);
    check("R9 no done continuous", done_cnt - base, 0);

    // R9 continuous leaky
    setup(2'b01, 16'd0, 16'h8000, 1'b1);
    feed(24'd100);
    check("R9 R7 leaky step1", result, 32'd50);
    feed(24'd100);
    check("R9 R7 leaky step2", result, 32'd75);
    check("R9 leaky no done", done_cnt - base, 0);

    // R9 free_run ignored in sum mode
    setup(2'b00, 16'd0, 16'd0, 1'b1);
    feed(24'd2); feed(24'd3);
    check("R9 sum ignores free_run done", {31'd0, done}, 32'd1);
    check("R9 sum ignores free_run result", result, 32'd5);

    finish_run();
  end

endmodule